// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block sits between a receive MAC byte stream and a packet buffer RAM. It takes one frame at a time as bytes marked with start and end flags and checks that the receiver is running and that the ring has room. It decides from the destination address whether the station wants the frame. A frame that is kept is written into a circular buffer built from 256-byte pages. The frame is padded to the minimum Ethernet size, and a 4-byte header in front of it carries a status byte, the page where the next frame will start and the stored length. When the header is written, the block hands the new current page to the register file around it and raises a one-cycle receive event.

The first six bytes (the destination address) are held in a six-deep delay line while the acceptance decision is made. The block never writes any RAM for a frame it refuses. The data bytes are written as the stream arrives. The header goes in after the last data byte, when the length is known.

The control flow is one state machine:
- `S_IDLE`: wait for a start byte.
- `S_SKIP`: discard a refused frame until its end byte.
- `S_ADDR`: collect the destination.
- `S_BODY`: stream the data into the ring.
- `S_DRAIN`: empty the delay line and write the zero padding.
- `S_HDR`: write the four header bytes.
- `S_DONE`: publish the current page and the status.

The transitions are:
- `S_IDLE` goes to `S_ADDR` on an accepted start.
- `S_IDLE` goes to `S_SKIP` on a refused start that is not also the end byte.
- `S_ADDR` goes to `S_BODY` when the sixth byte passes the filter.
- `S_ADDR` goes to `S_SKIP` or `S_IDLE` when it fails.
- `S_ADDR` goes to `S_IDLE` when the frame ends before six bytes.
- `S_ADDR` goes to `S_DRAIN` when the frame ends on its sixth byte and passes.
- `S_BODY` goes to `S_DRAIN` on the end byte.
- `S_DRAIN` goes to `S_HDR` after the last padded byte.
- `S_HDR` goes to `S_DONE` after the fourth header byte.
- `S_DONE` goes to `S_IDLE`.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the block makes no RAM write, `rx_ok_o` and `cur_pg_upd_o` are low, and `rx_status_o` and `cur_pg_o` are 0x00.
- R2: A frame whose start byte arrives while `stopped_i` is high produces no RAM write and no receive event.
- R3: A frame is refused when the stop page is not above the start page. It is also refused when the free space is below 1518 bytes. Free space is (boundary − current) × 256 when current < boundary, and otherwise ((stop − start) − (current − boundary)) × 256. With current = 0x48, a boundary of 0x4D is refused and 0x4E is accepted.
- R4: With `rx_mode_i[2]` (promiscuous) set, every frame of six bytes or more is accepted, whatever its destination.
- R5: A destination of six 0xFF bytes is accepted only when `rx_mode_i[0]` is set.
- R6: Any other destination whose first byte has bit 0 set is accepted only when `rx_mode_i[1]` is set and a bit of `mcast_hash_i` is set. That bit is chosen by the top 6 bits of a CRC-32 over the six destination bytes. The CRC starts at all ones and uses the polynomial 0x04C11DB7, shifted MSB first, with the bits of each byte fed LSB first and no final inversion.
- R7: A destination with bit 0 of its first byte clear is accepted only when it equals `station_addr_i`. The first byte on the wire is compared with bits [7:0], the second with bits [15:8], and so on.
- R8: A frame of fewer than 60 bytes is stored as 60 bytes, with zero bytes after the received ones.
- R9: The header of an accepted frame goes at byte address current page × 256. It holds, at offsets +0 to +3, the status byte, the next page, length low and length high, where length = stored bytes + 4. The data starts at offset +4.
- R10: The next page is (current × 256 + roundup256(length + 4)) / 256. When that address is at or past stop × 256, (stop − start) × 256 is first subtracted from it.
- R11: A data write whose address would reach stop × 256 continues at start × 256.
- R12: One cycle after the last header write, `rx_ok_o` and `cur_pg_upd_o` pulse for one cycle, `cur_pg_o` shows the next page, and `rx_status_o` shows 0x01, or 0x21 when the destination is a group address.
- R13: A frame that is refused or filtered, a frame that ends within its first six bytes, and a frame whose start byte arrives while an earlier frame is still being stored all produce no RAM write. For these frames `rx_status_o` does not change and there is no receive event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stopped_i | input | 1 | Receiver halted; new frames are refused |
| ring_start_pg_i | input | 8 | First page of the ring |
| ring_stop_pg_i | input | 8 | Page one past the end of the ring |
| bound_pg_i | input | 8 | Oldest page not yet freed by software |
| cur_pg_i | input | 8 | Page where the next frame is stored |
| rx_mode_i | input | 3 | [0] broadcast enable, [1] multicast enable, [2] promiscuous |
| station_addr_i | input | 48 | Own unicast address, first wire byte in [7:0] |
| mcast_hash_i | input | 64 | Multicast hash filter, bit n for hash index n |
| rx_valid_i | input | 1 | Byte present on `rx_data_i` |
| rx_sof_i | input | 1 | Byte is the first of a frame |
| rx_eof_i | input | 1 | Byte is the last of a frame |
| rx_data_i | input | 8 | Frame byte |
| ram_we_o | output | 1 | Buffer RAM write strobe |
| ram_addr_o | output | 16 | Buffer RAM byte address |
| ram_wdata_o | output | 8 | Buffer RAM write data |
| cur_pg_upd_o | output | 1 | One-cycle strobe: load `cur_pg_o` as current page |
| cur_pg_o | output | 8 | Updated current page |
| rx_status_o | output | 8 | Status byte of the last stored frame |
| rx_ok_o | output | 1 | One-cycle receive-complete event |

## Verification
A data byte's RAM write appears one cycle after the stream byte that pushes it out of the six-deep delay line. Each padded byte follows one cycle after the previous write. The four header writes come right after the last data write. The receive event and the page update come exactly one cycle after the final header write. The bench puts every expected write and event into scoreboard queues before it drives the frame. A monitor sampling on the falling edge pops one expected write for each strobe it sees, and on each receive event checks that the cycle before carried a write. After each frame the bench waits long enough for the longest drain and header sequence to finish, then requires both queues to be empty and the status to be as predicted.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SKIP,
        S_ADDR,
        S_BODY,
        S_DRAIN,
        S_HDR,
        S_DONE
    } rx_state_e;

    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam int MODE_BCAST   = 0;
    localparam int MODE_MCAST   = 1;
    localparam int MODE_PROMISC = 2;

    // Advance the address hash by one byte, bits taken LSB first.
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int k = 0; k < 8; k++) begin
            fb = r[31] ^ b[k];
            r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxr_delay_line.sv
module rxr_delay_line #(
    parameter int DEPTH = 6,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    logic [W-1:0] stage_q [DEPTH];

    generate
        for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
            if (gi == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)       stage_q[gi] <= '0;
                    else if (shift_i) stage_q[gi] <= din_i;
                end
            end else begin : g_tail
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)       stage_q[gi] <= '0;
                    else if (shift_i) stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    assign dout_o = stage_q[DEPTH-1];
endmodule

// File: rtl/rxr_addr_filter.sv
module rxr_addr_filter
    import rxr_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int POS_W      = 3,
    parameter int HASH_BITS  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_i,
    input  logic [POS_W-1:0]          pos_i,
    input  logic [7:0]                byte_i,
    input  logic [2:0]                mode_i,
    input  logic [8*ADDR_BYTES-1:0]   station_i,
    input  logic [(1<<HASH_BITS)-1:0] hash_tbl_i,
    output logic                      accept_o,
    output logic                      group_o
);
    localparam int SLOTS = 1 << POS_W;

    logic [7:0]  sta_b [SLOTS];
    logic [31:0] crc_q, crc_n;
    logic        bc_q, bc_n, uc_q, uc_n, grp_q, grp_n, first;
    logic [HASH_BITS-1:0] hidx;

    generate
        for (genvar gi = 0; gi < SLOTS; gi++) begin : g_sta
            if (gi < ADDR_BYTES) begin : g_real
                assign sta_b[gi] = station_i[8*gi +: 8];
            end else begin : g_pad
                assign sta_b[gi] = 8'h00;
            end
        end
    endgenerate

    always_comb begin
        first = (pos_i == '0);
        crc_n = crc_byte(first ? 32'hFFFF_FFFF : crc_q, byte_i);
        bc_n  = (first | bc_q) & (byte_i == 8'hFF);
        uc_n  = (first | uc_q) & (byte_i == sta_b[pos_i]);
        grp_n = first ? byte_i[0] : grp_q;
        hidx  = crc_n[31:32-HASH_BITS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
            bc_q  <= 1'b0;
            uc_q  <= 1'b0;
            grp_q <= 1'b0;
        end else if (push_i) begin
            crc_q <= crc_n;
            bc_q  <= bc_n;
            uc_q  <= uc_n;
            grp_q <= grp_n;
        end
    end

    // Decision is valid in the cycle the last destination byte is pushed.
    assign accept_o = mode_i[MODE_PROMISC]
                    | (bc_n  ? mode_i[MODE_BCAST]
                    :  grp_n ? (mode_i[MODE_MCAST] & hash_tbl_i[hidx])
                    :  uc_n);
    assign group_o  = grp_n;

    // R5: an all-ones destination passes without promiscuous only if broadcast is enabled
    p_bcast_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pos_i == POS_W'(ADDR_BYTES-1) && bc_n && accept_o && !mode_i[MODE_PROMISC])
            |-> mode_i[MODE_BCAST]);
endmodule

// File: rtl/rxr_ring_calc.sv
module rxr_ring_calc #(
    parameter int PG_W      = 8,
    parameter int OFS_W     = 8,
    parameter int LEN_W     = 16,
    parameter int MIN_FREE  = 1518,
    parameter int HDR_BYTES = 4,
    parameter int CRC_BYTES = 4
) (
    input  logic [PG_W-1:0]       start_pg_i,
    input  logic [PG_W-1:0]       stop_pg_i,
    input  logic [PG_W-1:0]       bound_pg_i,
    input  logic [PG_W-1:0]       cur_pg_i,
    output logic                  full_o,
    input  logic [PG_W+OFS_W-1:0] start_a_i,
    input  logic [PG_W+OFS_W-1:0] stop_a_i,
    input  logic [PG_W+OFS_W-1:0] base_a_i,
    input  logic [LEN_W-1:0]      len_i,
    output logic [PG_W-1:0]       next_pg_o,
    output logic [LEN_W-1:0]      total_o
);
    localparam int AW     = PG_W + OFS_W;
    localparam int XW     = ((AW > LEN_W) ? AW : LEN_W) + 3;
    localparam int SW     = PG_W + 3;
    localparam int MIN_PG = (MIN_FREE + (1 << OFS_W) - 1) >> OFS_W;
    localparam int PAGE   = 1 << OFS_W;

    logic signed [SW-1:0] s_start, s_stop, s_bnd, s_cur, avail_pg;
    logic [XW-1:0] tot, step, nxt;

    always_comb begin
        s_start = $signed({3'b000, start_pg_i});
        s_stop  = $signed({3'b000, stop_pg_i});
        s_bnd   = $signed({3'b000, bound_pg_i});
        s_cur   = $signed({3'b000, cur_pg_i});
        if (cur_pg_i < bound_pg_i) avail_pg = s_bnd - s_cur;
        else                       avail_pg = (s_stop - s_start) - (s_cur - s_bnd);
        full_o = (stop_pg_i <= start_pg_i) || (avail_pg < SW'(MIN_PG));
    end

    always_comb begin
        tot  = XW'(len_i) + XW'(HDR_BYTES);
        step = (tot + XW'(CRC_BYTES) + XW'(PAGE - 1)) & ~XW'(PAGE - 1);
        nxt  = XW'(base_a_i) + step;
        if (nxt >= XW'(stop_a_i)) nxt = nxt - (XW'(stop_a_i) - XW'(start_a_i));
        next_pg_o = nxt[AW-1:OFS_W];
        total_o   = tot[LEN_W-1:0];
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int PG_W       = 8,
    parameter int OFS_W      = 8,
    parameter int LEN_W      = 16,
    parameter int MIN_LEN    = 60,
    parameter int MIN_FREE   = 1518,
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      stopped_i,
    input  logic [PG_W-1:0]           ring_start_pg_i,
    input  logic [PG_W-1:0]           ring_stop_pg_i,
    input  logic [PG_W-1:0]           bound_pg_i,
    input  logic [PG_W-1:0]           cur_pg_i,
    input  logic [2:0]                rx_mode_i,
    input  logic [8*ADDR_BYTES-1:0]   station_addr_i,
    input  logic [(1<<HASH_BITS)-1:0] mcast_hash_i,
    input  logic                      rx_valid_i,
    input  logic                      rx_sof_i,
    input  logic                      rx_eof_i,
    input  logic [7:0]                rx_data_i,
    output logic                      ram_we_o,
    output logic [PG_W+OFS_W-1:0]     ram_addr_o,
    output logic [7:0]                ram_wdata_o,
    output logic                      cur_pg_upd_o,
    output logic [PG_W-1:0]           cur_pg_o,
    output logic [7:0]                rx_status_o,
    output logic                      rx_ok_o
);
    localparam int AW        = PG_W + OFS_W;
    localparam int POS_W     = $clog2(ADDR_BYTES + 1);
    localparam int HDR_BYTES = 4;

    rx_state_e state_q, state_n;

    logic [LEN_W-1:0] cnt_q, wr_cnt_q, len_pad, total;
    logic [AW-1:0]    start_a_q, stop_a_q, base_a_q, wr_a_q, wr_a_nx;
    logic [1:0]       hdr_idx_q;
    logic             grp_q;
    logic             beat, sof_beat, last_addr, drain_last, refuse;
    logic             flt_push, flt_accept, flt_group, ring_full;
    logic [POS_W-1:0] flt_pos;
    logic             dl_shift;
    logic [7:0]       dl_din, dl_dout, status_byte, hdr_byte;
    logic [PG_W-1:0]  next_pg;

    assign beat       = rx_valid_i;
    assign sof_beat   = rx_valid_i & rx_sof_i;
    assign last_addr  = (cnt_q == LEN_W'(ADDR_BYTES - 1));
    assign len_pad    = (cnt_q < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : cnt_q;
    assign drain_last = ((wr_cnt_q + 1'b1) == len_pad);
    assign refuse     = stopped_i | ring_full;
    assign wr_a_nx    = ((wr_a_q + 1'b1) == stop_a_q) ? start_a_q : (wr_a_q + 1'b1);

    assign flt_push = (state_q == S_IDLE && sof_beat) || (state_q == S_ADDR && beat);
    assign flt_pos  = (state_q == S_IDLE) ? '0 : cnt_q[POS_W-1:0];
    assign dl_shift = flt_push || (state_q == S_BODY && beat) || (state_q == S_DRAIN);
    assign dl_din   = (state_q == S_DRAIN) ? 8'h00 : rx_data_i;

    assign status_byte = 8'h01 | (grp_q ? 8'h20 : 8'h00);

    always_comb begin
        unique case (hdr_idx_q)
            2'd0:    hdr_byte = status_byte;
            2'd1:    hdr_byte = 8'(next_pg);
            2'd2:    hdr_byte = total[7:0];
            default: hdr_byte = total[15:8];
        endcase
    end

    rxr_addr_filter #(
        .ADDR_BYTES (ADDR_BYTES),
        .POS_W      (POS_W),
        .HASH_BITS  (HASH_BITS)
    ) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (flt_push),
        .pos_i      (flt_pos),
        .byte_i     (rx_data_i),
        .mode_i     (rx_mode_i),
        .station_i  (station_addr_i),
        .hash_tbl_i (mcast_hash_i),
        .accept_o   (flt_accept),
        .group_o    (flt_group)
    );

    rxr_ring_calc #(
        .PG_W      (PG_W),
        .OFS_W     (OFS_W),
        .LEN_W     (LEN_W),
        .MIN_FREE  (MIN_FREE),
        .HDR_BYTES (HDR_BYTES),
        .CRC_BYTES (4)
    ) u_ring (
        .start_pg_i (ring_start_pg_i),
        .stop_pg_i  (ring_stop_pg_i),
        .bound_pg_i (bound_pg_i),
        .cur_pg_i   (cur_pg_i),
        .full_o     (ring_full),
        .start_a_i  (start_a_q),
        .stop_a_i   (stop_a_q),
        .base_a_i   (base_a_q),
        .len_i      (len_pad),
        .next_pg_o  (next_pg),
        .total_o    (total)
    );

    rxr_delay_line #(
        .DEPTH (ADDR_BYTES),
        .W     (8)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (dl_shift),
        .din_i   (dl_din),
        .dout_o  (dl_dout)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: if (sof_beat) begin
                if (refuse)         state_n = rx_eof_i ? S_IDLE : S_SKIP;
                else                state_n = rx_eof_i ? S_IDLE : S_ADDR;
            end
            S_SKIP: if (beat && rx_eof_i) state_n = S_IDLE;
            S_ADDR: if (beat) begin
                if (last_addr) begin
                    if (!flt_accept) state_n = rx_eof_i ? S_IDLE : S_SKIP;
                    else             state_n = rx_eof_i ? S_DRAIN : S_BODY;
                end else if (rx_eof_i) begin
                    state_n = S_IDLE;
                end
            end
            S_BODY:  if (beat && rx_eof_i) state_n = S_DRAIN;
            S_DRAIN: if (drain_last) state_n = S_HDR;
            S_HDR:   if (hdr_idx_q == 2'd3) state_n = S_DONE;
            S_DONE:  state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            wr_cnt_q     <= '0;
            start_a_q    <= '0;
            stop_a_q     <= '0;
            base_a_q     <= '0;
            wr_a_q       <= '0;
            hdr_idx_q    <= '0;
            grp_q        <= 1'b0;
            ram_we_o     <= 1'b0;
            ram_addr_o   <= '0;
            ram_wdata_o  <= '0;
            cur_pg_upd_o <= 1'b0;
            cur_pg_o     <= '0;
            rx_status_o  <= '0;
            rx_ok_o      <= 1'b0;
        end else begin
            ram_we_o     <= 1'b0;
            cur_pg_upd_o <= 1'b0;
            rx_ok_o      <= 1'b0;
            unique case (state_q)
                S_IDLE: if (sof_beat) begin
                    start_a_q <= {ring_start_pg_i, OFS_W'(0)};
                    stop_a_q  <= {ring_stop_pg_i, OFS_W'(0)};
                    base_a_q  <= {cur_pg_i, OFS_W'(0)};
                    wr_a_q    <= {cur_pg_i, OFS_W'(HDR_BYTES)};
                    cnt_q     <= LEN_W'(1);
                    wr_cnt_q  <= '0;
                    hdr_idx_q <= '0;
                end
                S_ADDR: if (beat) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_addr) grp_q <= flt_group;
                end
                S_BODY: if (beat) begin
                    cnt_q       <= cnt_q + 1'b1;
                    ram_we_o    <= 1'b1;
                    ram_addr_o  <= wr_a_q;
                    ram_wdata_o <= dl_dout;
                    wr_a_q      <= wr_a_nx;
                    wr_cnt_q    <= wr_cnt_q + 1'b1;
                end
                S_DRAIN: begin
                    ram_we_o    <= 1'b1;
                    ram_addr_o  <= wr_a_q;
                    ram_wdata_o <= dl_dout;
                    wr_a_q      <= wr_a_nx;
                    wr_cnt_q    <= wr_cnt_q + 1'b1;
                end
                S_HDR: begin
                    ram_we_o    <= 1'b1;
                    ram_addr_o  <= base_a_q | AW'(hdr_idx_q);
                    ram_wdata_o <= hdr_byte;
                    hdr_idx_q   <= hdr_idx_q + 1'b1;
                end
                S_DONE: begin
                    rx_ok_o      <= 1'b1;
                    cur_pg_upd_o <= 1'b1;
                    cur_pg_o     <= next_pg;
                    rx_status_o  <= status_byte;
                end
                default: ;
            endcase
        end
    end

    // R13: no write can appear while the machine sits idle
    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !ram_we_o);

    // R11: every write lands inside the ring latched for the frame
    p_in_ring_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (ram_addr_o >= start_a_q && ram_addr_o < stop_a_q));

    // R12: receive event is a single-cycle pulse
    p_ok_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok_o |=> !rx_ok_o);

    // R12: status carries only the OK bit and the group bit
    p_ok_status_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok_o |-> (rx_status_o[0] && (rx_status_o & 8'hDE) == 8'h00));

    // R2: a start byte while halted never enters address collection
    p_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && sof_beat && stopped_i) |=> (state_q != S_ADDR));
endmodule

// File: tb/rx_ring_writer_tb_top.sv
module rx_ring_writer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stopped = 1'b0;
    logic [7:0]  start_pg = 8'h40, stop_pg = 8'h60, bnd_pg = 8'h40, cur_pg = 8'h40;
    logic [2:0]  mode = 3'b000;
    logic [47:0] station = {8'h56, 8'h34, 8'h12, 8'h00, 8'h54, 8'h52};
    logic [63:0] htbl = '0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = 8'h00;

    logic        ram_we, cur_pg_upd, rx_ok;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata, cur_pg_out, rx_status;

    always #4 clk = ~clk;   // 125 MHz

    rx_ring_writer dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .stopped_i       (stopped),
        .ring_start_pg_i (start_pg),
        .ring_stop_pg_i  (stop_pg),
        .bound_pg_i      (bnd_pg),
        .cur_pg_i        (cur_pg),
        .rx_mode_i       (mode),
        .station_addr_i  (station),
        .mcast_hash_i    (htbl),
        .rx_valid_i      (rx_valid),
        .rx_sof_i        (rx_sof),
        .rx_eof_i        (rx_eof),
        .rx_data_i       (rx_data),
        .ram_we_o        (ram_we),
        .ram_addr_o      (ram_addr),
        .ram_wdata_o     (ram_wdata),
        .cur_pg_upd_o    (cur_pg_upd),
        .cur_pg_o        (cur_pg_out),
        .rx_status_o     (rx_status),
        .rx_ok_o         (rx_ok)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    string tag = "R1";
    logic [7:0] fb [0:511];
    int    wq_a [$];
    int    wq_d [$];
    int    okq  [$];
    int    last_status = 0;
    int    pend_cur = -1;
    bit    prev_we = 1'b0;

    task automatic chk(input bit ok, input string t, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_we) begin
                if (wq_a.size() == 0) begin
                    chk(1'b0, tag, "unexpected RAM write addr", int'(ram_addr), -1);
                end else begin
                    int ea, ed;
                    ea = wq_a.pop_front();
                    ed = wq_d.pop_front();
                    chk(int'(ram_addr) == ea, tag, "write address", int'(ram_addr), ea);
                    chk(int'(ram_wdata) == ed, tag, "write data", int'(ram_wdata), ed);
                end
            end
            if (rx_ok) begin
                if (okq.size() == 0) begin
                    chk(1'b0, tag, "unexpected receive event", int'(rx_status), -1);
                end else begin
                    int e;
                    e = okq.pop_front();
                    chk(prev_we, "R12", "event one cycle after last write", int'(prev_we), 1);
                    chk(cur_pg_upd, "R12", "page update strobe", int'(cur_pg_upd), 1);
                    chk(int'(cur_pg_out) == (e >> 8), "R10", "next page", int'(cur_pg_out), e >> 8);
                    chk(int'(rx_status) == (e & 255), "R12", "status byte", int'(rx_status), e & 255);
                    chk(wq_a.size() == 0, "R9", "writes left at event", wq_a.size(), 0);
                    last_status = e & 255;
                end
            end
            prev_we = ram_we;
        end
    end

    function automatic int tb_hash();
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            for (int k = 0; k < 8; k++) begin
                bit t;
                t = c[31] ^ fb[i][k];
                c = c << 1;
                if (t) c = c ^ 32'h04C11DB7;
            end
        end
        return int'(c[31:26]);
    endfunction

    function automatic bit tb_full();
        int st, sp, c, b, av;
        st = int'(start_pg) * 256; sp = int'(stop_pg) * 256;
        c  = int'(cur_pg) * 256;   b  = int'(bnd_pg) * 256;
        if (sp <= st) return 1'b1;
        av = (c < b) ? (b - c) : ((sp - st) - (c - b));
        return av < 1518;
    endfunction

    function automatic bit tb_accept(input int n);
        bit bc, uc;
        if (stopped || tb_full() || n < 6) return 1'b0;
        if (mode[2]) return 1'b1;
        bc = 1'b1; uc = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (fb[i] != 8'hFF) bc = 1'b0;
            if (fb[i] != station[8*i +: 8]) uc = 1'b0;
        end
        if (bc) return mode[0];
        if (fb[0][0]) return mode[1] && htbl[tb_hash()];
        return uc;
    endfunction

    task automatic set_dest(input logic [7:0] a0, a1, a2, a3, a4, a5);
        fb[0] = a0; fb[1] = a1; fb[2] = a2; fb[3] = a3; fb[4] = a4; fb[5] = a5;
    endtask

    task automatic fill_payload(input int seed);
        for (int i = 6; i < 512; i++) fb[i] = 8'(i * 13 + seed);
    endtask

    task automatic expect_frame(input int n);
        int len, tot, base, nxt, a, sp, st, stat;
        if (!tb_accept(n)) return;
        len  = (n < 60) ? 60 : n;
        tot  = len + 4;
        base = int'(cur_pg) * 256;
        st   = int'(start_pg) * 256;
        sp   = int'(stop_pg) * 256;
        nxt  = base + ((tot + 4 + 255) / 256) * 256;
        if (nxt >= sp) nxt = nxt - (sp - st);
        stat = fb[0][0] ? 8'h21 : 8'h01;
        a = base + 4;
        for (int i = 0; i < len; i++) begin
            wq_a.push_back(a);
            wq_d.push_back((i < n) ? int'(fb[i]) : 0);
            a = a + 1;
            if (a == sp) a = st;
        end
        wq_a.push_back(base);     wq_d.push_back(stat);
        wq_a.push_back(base + 1); wq_d.push_back(nxt / 256);
        wq_a.push_back(base + 2); wq_d.push_back(tot & 255);
        wq_a.push_back(base + 3); wq_d.push_back(tot / 256);
        okq.push_back(((nxt / 256) << 8) | stat);
        pend_cur = nxt / 256;
    endtask

    task automatic drive(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1); rx_data = fb[i];
            if (gaps && (i % 5 == 2)) begin
                @(negedge clk);
                rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic finish_frame(input string t);
        repeat (120) @(negedge clk);
        chk(wq_a.size() == 0, t, "expected writes not seen", wq_a.size(), 0);
        chk(okq.size() == 0, t, "expected event not seen", okq.size(), 0);
        chk(int'(rx_status) == last_status, t, "status after frame", int'(rx_status), last_status);
        if (pend_cur >= 0) cur_pg = 8'(pend_cur);
        pend_cur = -1;
    endtask

    task automatic run_frame(input int n, input bit gaps, input string t);
        tag = t;
        expect_frame(n);
        drive(n, gaps);
        finish_frame(t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int h;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ram_we, "R1", "ram_we after reset", int'(ram_we), 0);
        chk(!rx_ok && !cur_pg_upd, "R1", "event after reset", int'(rx_ok), 0);
        chk(rx_status == 8'h00, "R1", "status after reset", int'(rx_status), 0);
        chk(cur_pg_out == 8'h00, "R1", "page after reset", int'(cur_pg_out), 0);

        // R7 R9 R10 R12: unicast match
        fill_payload(1);
        set_dest(8'h52, 8'h54, 8'h00, 8'h12, 8'h34, 8'h56);
        run_frame(70, 1'b0, "R7/R9/R12");
        chk(cur_pg == 8'h41, "R10", "page advance for 70 bytes", int'(cur_pg), 8'h41);

        // R7 R13: unicast mismatch
        set_dest(8'h52, 8'h54, 8'h00, 8'h12, 8'h34, 8'h57);
        run_frame(70, 1'b0, "R7/R13");

        // R8: short frame padded
        fill_payload(9);
        set_dest(8'h52, 8'h54, 8'h00, 8'h12, 8'h34, 8'h56);
        run_frame(20, 1'b1, "R8");

        // R5: broadcast
        set_dest(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        mode = 3'b000;
        run_frame(64, 1'b0, "R5/R13");
        mode = 3'b001;
        run_frame(64, 1'b0, "R5/R12");

        // R6: multicast hash
        set_dest(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'hFB);
        h = tb_hash();
        mode = 3'b010; htbl = 64'd1 << h;
        run_frame(80, 1'b0, "R6");
        htbl = ~(64'd1 << h);
        run_frame(80, 1'b0, "R6/R13");
        mode = 3'b000; htbl = 64'd1 << h;
        run_frame(80, 1'b0, "R6/R13");

        // R4: promiscuous
        mode = 3'b100;
        set_dest(8'h02, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE);
        run_frame(66, 1'b1, "R4");
        mode = 3'b000;

        // R2: stopped
        set_dest(8'h52, 8'h54, 8'h00, 8'h12, 8'h34, 8'h56);
        stopped = 1'b1;
        run_frame(70, 1'b0, "R2");
        stopped = 1'b0;

        // R3: ring full boundaries
        cur_pg = 8'h48; bnd_pg = 8'h4D;
        run_frame(70, 1'b0, "R3");
        chk(cur_pg == 8'h48, "R3", "page unchanged when full", int'(cur_pg), 8'h48);
        bnd_pg = 8'h4E;
        run_frame(70, 1'b0, "R3");
        chk(cur_pg == 8'h49, "R3", "accepted at 6 free pages", int'(cur_pg), 8'h49);
        start_pg = 8'h60;
        run_frame(70, 1'b0, "R3");
        start_pg = 8'h40;

        // R10 R11: wrap at stop
        cur_pg = 8'h5F; bnd_pg = 8'h50;
        fill_payload(5);
        run_frame(300, 1'b1, "R10/R11");
        chk(cur_pg == 8'h41, "R10", "wrapped next page", int'(cur_pg), 8'h41);

        // R13: runt frame dropped
        run_frame(4, 1'b0, "R13");

        // R13: frame starting while previous is stored is dropped
        tag = "R13";
        expect_frame(70);
        drive(70, 1'b0);
        drive(70, 1'b0);
        finish_frame("R13");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule